// File: doc/BRIEF.md
# Host Port Slave with Ready Handshake

This block lets an external host processor reach a small set of registers and a 32-bit data path over a 16-bit multiplexed bus. The host drives a chip select, a data strobe, a read/write line, a 2-bit register select, a halfword-select line and an optional address strobe. A 32-bit quantity moves as two halfword cycles. The block answers each cycle with an active-low ready line. It holds that line high, which inserts wait states, until the register or FIFO the host has addressed can complete the access.

Behind the host side there are two FIFOs of 8 words of 32 bits each. The memory side pushes words into the read FIFO and pops words from the write FIFO. It also sees the current address register. All host pins pass through two-flop synchronizers into the core clock domain. The inverted OR of chip select and data strobe forms an internal strobe. The falling edge of that strobe latches the control lines, unless the address strobe has already latched them. The rising edge of the strobe completes the access.

Ready is computed again on every core clock from the latched selection and the FIFO levels. A host that ends its strobe before ready arrives gets an aborted cycle, which changes neither FIFO nor the address. The control register mirrors its low half onto its high half, so a single halfword read is enough. It also reports data-path readiness, for hosts that have no ready input.

Top module: `hbus_slave`

## Requirements
- R1: After reset, rdy_n is 1, hdata_oe is 0, rf_full is 0 and wf_empty is 1.
- R2: rdy_n is driven low only while an internal strobe (cs_n and ds_n both low) is in progress. rdy_n is back at 1 once the strobe has ended, and it stays at 1 between cycles.
- R3: A data-register read holds rdy_n at 1 while the read FIFO is empty. A write of the second halfword (hsel=1) to the data register holds rdy_n at 1 while the write FIFO holds 8 words. rdy_n falls without any host action once the condition clears.
- R4: The control register reads as bit 0 = read FIFO not empty and bit 1 = write FIFO not full, with all other bits 0. It returns this same 16-bit value for hsel=0 and hsel=1. Host writes to it change nothing.
- R5: The rsel codes are 00 = control register, 01 = address register, 10 = data register with auto-increment, and 11 = data register without auto-increment. For address accesses, hsel=0 selects address bits 15:0 and hsel=1 selects bits 31:16.
- R6: A data word moves as two halfwords, hsel=0 carrying bits 15:0 and hsel=1 carrying bits 31:16. A read pops the FIFO head when its hsel=1 halfword completes. A write pushes {high, low} when its hsel=1 halfword completes. Words leave each FIFO in the order they entered.
- R7: Each completed data-word transfer selected with rsel=10 adds 4 to the address register. A transfer selected with rsel=11 leaves the address unchanged.
- R8: A strobe that ends while rdy_n is still 1 aborts the cycle. It pops nothing, pushes nothing, and leaves the address unchanged.
- R9: A falling edge of as_n latches rnw, rsel and hsel. Those lines are then ignored at the strobe's falling edge. A falling edge of as_n during a cycle that is not yet ready latches new control information and starts a new cycle.
- R10: Each FIFO holds at most 8 words. rf_full is 1 at 8 words, and a memory-side push into a full read FIFO is dropped.
- R11: wf_rdata shows the oldest word in the write FIFO. wf_empty is 1 when the write FIFO holds no words. A wf_pop while the write FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| ds_n | input | 1 | Host data strobe, active low |
| as_n | input | 1 | Host address strobe, active low; tie high if unused |
| rnw | input | 1 | 1 = read, 0 = write |
| rsel | input | 2 | Register select |
| hsel | input | 1 | Halfword select, 0 = first (low) halfword |
| hdata_in | input | 16 | Host write data |
| hdata_out | output | 16 | Host read data |
| hdata_oe | output | 1 | Host bus drive enable during reads |
| rdy_n | output | 1 | Ready, active low |
| rf_push | input | 1 | Memory side pushes a word into the read FIFO |
| rf_wdata | input | 32 | Word pushed into the read FIFO |
| rf_full | output | 1 | Read FIFO holds 8 words |
| wf_pop | input | 1 | Memory side pops the write FIFO head |
| wf_rdata | output | 32 | Write FIFO head word |
| wf_empty | output | 1 | Write FIFO holds no words |
| mem_addr | output | 32 | Current address register |

## Verification
Two functions can land in the same cycle: a host data read that is waiting on an empty read FIFO, and a memory-side push that fills that FIFO. The bench opens a read strobe on an empty FIFO and confirms that ready stays high. It then pushes a word from the memory side while the strobe is still held, and expects ready to fall by itself with the pushed word on the bus. A second collision comes from re-latching control through the address strobe during a stalled cycle. There the bench expects the control-register value to replace the stalled data read.

// File: rtl/hbus_slave.sv
module hbus_slave #(
  parameter int DEPTH     = 8,
  parameter int ADDR_STEP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        ds_n,
  input  logic        as_n,
  input  logic        rnw,
  input  logic [1:0]  rsel,
  input  logic        hsel,
  input  logic [15:0] hdata_in,
  output logic [15:0] hdata_out,
  output logic        hdata_oe,
  output logic        rdy_n,
  input  logic        rf_push,
  input  logic [31:0] rf_wdata,
  output logic        rf_full,
  input  logic        wf_pop,
  output logic [31:0] wf_rdata,
  output logic        wf_empty,
  output logic [31:0] mem_addr
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] SEL_CTRL = 2'b00;
  localparam logic [1:0] SEL_ADDR = 2'b01;
  localparam logic [1:0] SEL_DINC = 2'b10;

  logic [1:0]  stb_q, as_q;
  logic        stb_prev, as_prev;
  logic [3:0]  ctl_s1, ctl_s2;
  logic [15:0] din_s1, din_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q    <= 2'b11;
      as_q     <= 2'b11;
      stb_prev <= 1'b1;
      as_prev  <= 1'b1;
      ctl_s1   <= '0;
      ctl_s2   <= '0;
      din_s1   <= '0;
      din_s2   <= '0;
    end else begin
      stb_q    <= {stb_q[0], cs_n | ds_n};
      as_q     <= {as_q[0], as_n};
      stb_prev <= stb_q[1];
      as_prev  <= as_q[1];
      ctl_s1   <= {rnw, rsel, hsel};
      ctl_s2   <= ctl_s1;
      din_s1   <= hdata_in;
      din_s2   <= din_s1;
    end
  end

  wire stb_s    = stb_q[1];
  wire stb_fall = stb_prev & ~stb_s;
  wire stb_rise = ~stb_prev & stb_s;
  wire as_fall  = as_prev & ~as_q[1];

  logic       act, as_held, lat_rnw, lat_hsel;
  logic [1:0] lat_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= 1'b0;
      as_held  <= 1'b0;
      lat_rnw  <= 1'b0;
      lat_sel  <= SEL_CTRL;
      lat_hsel <= 1'b0;
    end else begin
      if (as_fall || (stb_fall && !as_held))
        {lat_rnw, lat_sel, lat_hsel} <= ctl_s2;
      if (as_fall)       as_held <= 1'b1;
      else if (stb_rise) as_held <= 1'b0;
      if (stb_fall)      act <= 1'b1;
      else if (stb_rise) act <= 1'b0;
    end
  end

  logic [31:0] rf_mem [DEPTH];
  logic [31:0] wf_mem [DEPTH];
  logic [PW-1:0] rf_wp, rf_rp, wf_wp, wf_rp;
  logic [CW-1:0] rf_cnt, wf_cnt;
  logic [15:0]   wlow;

  wire rf_nemp  = rf_cnt != '0;
  wire wf_nfull = wf_cnt != CW'(DEPTH);
  wire lat_data = lat_sel[1];
  wire ok_now   = !lat_data || (lat_rnw ? rf_nemp : (!lat_hsel || wf_nfull));
  wire done     = stb_rise & act & ~rdy_n;
  wire rf_pop_h  = done & lat_rnw & lat_data & lat_hsel & rf_nemp;
  wire wf_push_h = done & ~lat_rnw & lat_data & lat_hsel & wf_nfull;
  wire rf_do_push = rf_push & (rf_cnt != CW'(DEPTH));
  wire wf_do_pop  = wf_pop & (wf_cnt != '0);
  wire [15:0] ctrl_val = {14'b0, wf_nfull, rf_nemp};

  always_ff @(posedge clk) begin
    if (rf_do_push) rf_mem[rf_wp] <= rf_wdata;
    if (wf_push_h)  wf_mem[wf_wp] <= {din_s2, wlow};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_wp <= '0; rf_rp <= '0; rf_cnt <= '0;
      wf_wp <= '0; wf_rp <= '0; wf_cnt <= '0;
      wlow <= '0; mem_addr <= '0; rdy_n <= 1'b1; hdata_out <= '0;
    end else begin
      rf_wp  <= rf_wp + PW'(rf_do_push);
      rf_rp  <= rf_rp + PW'(rf_pop_h);
      rf_cnt <= rf_cnt + CW'(rf_do_push) - CW'(rf_pop_h);
      wf_wp  <= wf_wp + PW'(wf_push_h);
      wf_rp  <= wf_rp + PW'(wf_do_pop);
      wf_cnt <= wf_cnt + CW'(wf_push_h) - CW'(wf_do_pop);
      rdy_n  <= ~(act & ~stb_rise & ~as_fall & ok_now);
      if (done && !lat_rnw && lat_data && !lat_hsel) wlow <= din_s2;
      if (done && !lat_rnw && lat_sel == SEL_ADDR) begin
        if (lat_hsel) mem_addr[31:16] <= din_s2;
        else          mem_addr[15:0]  <= din_s2;
      end else if ((rf_pop_h || wf_push_h) && lat_sel == SEL_DINC)
        mem_addr <= mem_addr + 32'(ADDR_STEP);
      case (lat_sel)
        SEL_CTRL: hdata_out <= ctrl_val;
        SEL_ADDR: hdata_out <= lat_hsel ? mem_addr[31:16] : mem_addr[15:0];
        default:  hdata_out <= lat_hsel ? rf_mem[rf_rp][31:16] : rf_mem[rf_rp][15:0];
      endcase
    end
  end

  assign hdata_oe = act & lat_rnw;
  assign rf_full  = rf_cnt == CW'(DEPTH);
  assign wf_empty = wf_cnt == '0;
  assign wf_rdata = wf_mem[wf_rp];
endmodule

// File: rtl/hbus_slave_chk.sv
module hbus_slave_chk #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rdy_n,
  input logic                       stb_s,
  input logic                       stb_rise,
  input logic                       lat_rnw,
  input logic [1:0]                 lat_sel,
  input logic                       lat_hsel,
  input logic [$clog2(DEPTH+1)-1:0] rf_cnt,
  input logic [$clog2(DEPTH+1)-1:0] wf_cnt,
  input logic                       wf_pop,
  input logic [31:0]                mem_addr
);
  localparam int CW = $clog2(DEPTH + 1);

  p_rd_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_n && lat_rnw && lat_sel[1]) |-> (rf_cnt != '0));

  p_wr_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_n && !lat_rnw && lat_sel[1] && lat_hsel) |-> (wf_cnt != CW'(DEPTH)));

  p_idle_rdy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb_s |-> ##2 rdy_n);

  p_abort_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && rdy_n) |=> $stable(mem_addr));

  p_abort_wf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && rdy_n && !wf_pop) |=> (wf_cnt <= $past(wf_cnt)));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_cnt <= CW'(DEPTH)) && (wf_cnt <= CW'(DEPTH)));
endmodule

bind hbus_slave hbus_slave_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy_n(rdy_n), .stb_s(stb_s), .stb_rise(stb_rise),
  .lat_rnw(lat_rnw), .lat_sel(lat_sel), .lat_hsel(lat_hsel),
  .rf_cnt(rf_cnt), .wf_cnt(wf_cnt), .wf_pop(wf_pop), .mem_addr(mem_addr)
);

// File: tb/hbus_slave_bench.sv
module hbus_slave_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ds_n = 1'b1, as_n = 1'b1, rnw = 1'b1, hsel = 1'b0;
  logic [1:0]  rsel = 2'b00;
  logic [15:0] hdata_in = '0;
  logic [15:0] hdata_out;
  logic        hdata_oe, rdy_n, rf_full, wf_empty;
  logic        rf_push = 1'b0, wf_pop = 1'b0;
  logic [31:0] rf_wdata = '0;
  logic [31:0] wf_rdata, mem_addr;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] q_rf[$];
  logic [31:0] q_wf[$];
  logic [31:0] m_addr = '0;

  always #5 clk = ~clk;

  hbus_slave u_hbus_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds_n(ds_n), .as_n(as_n), .rnw(rnw),
    .rsel(rsel), .hsel(hsel), .hdata_in(hdata_in), .hdata_out(hdata_out),
    .hdata_oe(hdata_oe), .rdy_n(rdy_n), .rf_push(rf_push), .rf_wdata(rf_wdata),
    .rf_full(rf_full), .wf_pop(wf_pop), .wf_rdata(wf_rdata), .wf_empty(wf_empty),
    .mem_addr(mem_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_ctrl();
    return {14'b0, q_wf.size() < 8, q_rf.size() != 0};
  endfunction

  task automatic drive(input logic r, input logic [1:0] s, input logic h, input logic [15:0] d);
    @(negedge clk);
    rnw = r; rsel = s; hsel = h; hdata_in = d;
  endtask

  task automatic wait_rdy(input int maxw, output bit got);
    got = 0;
    for (int i = 0; i < maxw; i++) begin
      @(negedge clk);
      if (!rdy_n) begin got = 1; break; end
    end
  endtask

  task automatic strobe_off();
    @(negedge clk);
    cs_n = 1'b1; ds_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic host_cycle(input logic r, input logic [1:0] s, input logic h,
                            input logic [15:0] d, input int maxw,
                            output logic [15:0] q, output bit got);
    drive(r, s, h, d);
    cs_n = 1'b0; ds_n = 1'b0;
    wait_rdy(maxw, got);
    q = hdata_out;
    strobe_off();
  endtask

  task automatic mem_push(input logic [31:0] v);
    @(negedge clk);
    rf_push = 1'b1; rf_wdata = v;
    @(negedge clk);
    rf_push = 1'b0;
    if (q_rf.size() < 8) q_rf.push_back(v);
  endtask

  task automatic mem_pop();
    @(negedge clk);
    check("R11 wf_empty", {31'b0, wf_empty}, {31'b0, q_wf.size() == 0});
    if (q_wf.size() != 0) check("R6 write order", wf_rdata, q_wf.pop_front());
    wf_pop = 1'b1;
    @(negedge clk);
    wf_pop = 1'b0;
  endtask

  task automatic read_word(input logic [1:0] s);
    logic [15:0] lo, hi;
    bit g0, g1;
    if (q_rf.size() == 0) begin
      host_cycle(1'b1, s, 1'b0, 16'h0, 12, lo, g0);
      check("R3 read waits on empty (R8 abort)", {31'b0, g0}, 32'd0);
    end else begin
      host_cycle(1'b1, s, 1'b0, 16'h0, 40, lo, g0);
      host_cycle(1'b1, s, 1'b1, 16'h0, 40, hi, g1);
      check("R3 read ready", {30'b0, g0, g1}, 32'd3);
      check("R6 read word", {hi, lo}, q_rf.pop_front());
      if (s == 2'b10) m_addr = m_addr + 32'd4;
    end
  endtask

  task automatic write_word(input logic [1:0] s, input logic [31:0] v);
    logic [15:0] q;
    bit g0, g1;
    host_cycle(1'b0, s, 1'b0, v[15:0], 40, q, g0);
    check("R3 low half ready", {31'b0, g0}, 32'd1);
    if (q_wf.size() >= 8) begin
      host_cycle(1'b0, s, 1'b1, v[31:16], 12, q, g1);
      check("R3 write waits on full (R8 abort)", {31'b0, g1}, 32'd0);
    end else begin
      host_cycle(1'b0, s, 1'b1, v[31:16], 40, q, g1);
      check("R3 high half ready", {31'b0, g1}, 32'd1);
      q_wf.push_back(v);
      if (s == 2'b10) m_addr = m_addr + 32'd4;
    end
  endtask

  task automatic check_addr(input string req);
    logic [15:0] lo, hi;
    bit g;
    host_cycle(1'b1, 2'b01, 1'b0, 16'h0, 40, lo, g);
    host_cycle(1'b1, 2'b01, 1'b1, 16'h0, 40, hi, g);
    check(req, {hi, lo}, m_addr);
    check({req, " mem_addr"}, mem_addr, m_addr);
  endtask

  task automatic check_ctrl(input logic h, input string req);
    logic [15:0] q;
    bit g;
    host_cycle(1'b1, 2'b00, h, 16'h0, 40, q, g);
    check(req, {16'b0, q}, {16'b0, exp_ctrl()});
  endtask

  task automatic write_addr(input logic [31:0] a);
    logic [15:0] q;
    bit g;
    host_cycle(1'b0, 2'b01, 1'b0, a[15:0], 40, q, g);
    host_cycle(1'b0, 2'b01, 1'b1, a[31:16], 40, q, g);
    m_addr = a;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] q;
    bit g;
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 rdy_n", {31'b0, rdy_n}, 32'd1);
    check("R1 hdata_oe", {31'b0, hdata_oe}, 32'd0);
    check("R1 rf_full", {31'b0, rf_full}, 32'd0);
    check("R1 wf_empty", {31'b0, wf_empty}, 32'd1);

    check_ctrl(1'b0, "R4 ctrl hsel0");
    check_ctrl(1'b1, "R4 ctrl hsel1");
    host_cycle(1'b0, 2'b00, 1'b0, 16'hFFFF, 40, q, g);
    host_cycle(1'b0, 2'b00, 1'b1, 16'hFFFF, 40, q, g);
    check_ctrl(1'b0, "R4 ctrl write ignored");

    write_addr(32'h1234_5670);
    check_addr("R5 address readback");
    check("R2 idle after cycle", {31'b0, rdy_n}, 32'd1);

    // R10: fill read FIFO and overflow it
    for (int i = 0; i < 9; i++) mem_push(32'hA000_0000 + i);
    @(negedge clk);
    check("R10 rf_full", {31'b0, rf_full}, 32'd1);
    // R2: output enable while a read strobe is held
    drive(1'b1, 2'b00, 1'b0, 16'h0);
    cs_n = 1'b0; ds_n = 1'b0;
    wait_rdy(40, g);
    check("R2 hdata_oe on read", {31'b0, hdata_oe}, 32'd1);
    strobe_off();
    check("R2 rdy_n after strobe", {31'b0, rdy_n}, 32'd1);
    for (int i = 0; i < 8; i++) read_word(2'b10);
    check_addr("R7 auto-increment");
    mem_push(32'hBEEF_0001);
    read_word(2'b11);
    check_addr("R7 fixed address");
    read_word(2'b10);
    check_addr("R8 aborted read keeps address");
    check_ctrl(1'b1, "R4 ctrl empty read FIFO");

    // R3: read stalls on empty, memory-side push releases it
    drive(1'b1, 2'b11, 1'b0, 16'h0);
    cs_n = 1'b0; ds_n = 1'b0;
    repeat (8) @(negedge clk);
    check("R3 stalled read", {31'b0, rdy_n}, 32'd1);
    mem_push(32'h5A5A_C3C3);
    wait_rdy(40, g);
    check("R3 ready after push", {31'b0, g}, 32'd1);
    check("R3 data after push", {16'b0, hdata_out}, 32'h0000_C3C3);
    strobe_off();
    host_cycle(1'b1, 2'b11, 1'b1, 16'h0, 40, q, g);
    check("R6 high half after push", {16'b0, q}, 32'h0000_5A5A);
    void'(q_rf.pop_front());

    // R9: relatch while stalled
    drive(1'b1, 2'b11, 1'b0, 16'h0);
    cs_n = 1'b0; ds_n = 1'b0;
    wait_rdy(10, g);
    check("R9 stalled before relatch", {31'b0, g}, 32'd0);
    drive(1'b1, 2'b00, 1'b0, 16'h0);
    as_n = 1'b0;
    wait_rdy(40, g);
    check("R9 relatch ready", {31'b0, g}, 32'd1);
    check("R9 relatch value", {16'b0, hdata_out}, {16'b0, exp_ctrl()});
    strobe_off();
    as_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: early latch, lines changed before strobe
    drive(1'b1, 2'b01, 1'b0, 16'h0);
    as_n = 1'b0;
    repeat (4) @(negedge clk);
    rsel = 2'b00; hsel = 1'b1;
    cs_n = 1'b0; ds_n = 1'b0;
    wait_rdy(40, g);
    check("R9 early latch", {16'b0, hdata_out}, {16'b0, m_addr[15:0]});
    strobe_off();
    as_n = 1'b1;
    repeat (3) @(negedge clk);

    // write FIFO fill, overflow abort, drain
    for (int i = 0; i < 9; i++) write_word(2'b10, 32'hC000_0100 + i);
    check_ctrl(1'b0, "R4 ctrl full write FIFO");
    check_addr("R8 address after aborted write");
    for (int i = 0; i < 8; i++) mem_pop();
    mem_pop();
    check("R11 empty after pop on empty", {31'b0, wf_empty}, 32'd1);
    write_word(2'b11, 32'h0BAD_F00D);
    mem_pop();

    // constrained random mix
    for (int n = 0; n < 300; n++) begin
      case ($urandom_range(0, 6))
        0: mem_push($urandom);
        1: mem_pop();
        2: read_word($urandom_range(0, 1) ? 2'b10 : 2'b11);
        3: write_word($urandom_range(0, 1) ? 2'b10 : 2'b11, $urandom);
        4: check_ctrl(1'($urandom_range(0, 1)), "R4 random ctrl");
        5: check_addr("R5 random address");
        default: write_addr({$urandom} & 32'hFFFF_FFFC);
      endcase
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule